// File: doc/BRIEF.md
# Idle-Qualified Power-Down Request Filter

This block decides when a serial port and a pair of general-purpose pins have been quiet long enough to justify powering the function down. It looks at three status signals from a UART: an interrupt-pending flag, a transmitter-idle flag and a receiver-idle flag. It also looks at the levels of two multipurpose pins. Each source has its own enable. Each pin has a polarity bit that names the level at which the pin would raise an interrupt. A pin counts as quiet when it sits at the opposite level.

When any enabled source is quiet, a qualification timer starts. A 3-bit filter code sets the timer length in prescaled ticks. The timer restarts from zero whenever the combined request drops, even for a single cycle. The status bit is set only when the request has stayed valid for the whole window. Software can poll the status bit or, when the interrupt enable is set, receive it as an interrupt. Once software has acknowledged a status event, no new event is reported until the request has gone away and qualified again. This keeps bursty activity from producing a stream of power-down interrupts.

Top module: `pwr_idle_filter`

## Requirements
- R1: The UART source is quiet only when `uart_pd_en` is 1, `uart_irq_pend` is 0, and both `uart_tx_idle` and `uart_rx_idle` are 1. Any single condition that fails keeps this source from requesting.
- R2: Pin i requests only when `mio_pd_en[i]` is 1 and its synchronized level differs from `mio_irq_pol[i]` (polarity 1 means a high level raises the interrupt). Pins pass through a two-flop synchronizer, so a pin change reaches the request on the third rising edge after it.
- R3: `pd_stat` becomes 1 right after the N-th consecutive rising edge at which the combined request is true, where N = 2^(`filt_sel`+4) × PRESCALE. It is 0 after edge N-1.
- R4: A single edge with the request false resets the qualification timer to zero, so the full N edges are needed again.
- R5: `pd_stat` returns to 0 after the first rising edge at which the combined request is false.
- R6: `pd_stat_clr` high at a rising edge while `pd_stat` is 1 clears `pd_stat`. The status is not set again until the request has dropped and then qualified again.
- R7: `pd_irq` is 1 exactly when `pd_stat` is 1 and `pd_irq_en` is 1. With `pd_irq_en` at 0 the status can only be polled.
- R8: During and right after reset, `pd_stat` and `pd_irq` are 0.
- R9: When qualification completes at the same edge on which `pd_stat_clr` is high, the status is set. The clear then takes effect at a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_irq_pend | input | 1 | UART has an interrupt pending |
| uart_tx_idle | input | 1 | UART transmitter idle |
| uart_rx_idle | input | 1 | UART receiver idle |
| uart_pd_en | input | 1 | Enables the UART as a power-down source |
| mio_pin | input | MIO_N | Multipurpose pin levels (asynchronous) |
| mio_irq_pol | input | MIO_N | Level at which each pin raises its interrupt |
| mio_pd_en | input | MIO_N | Enables each pin as a power-down source |
| filt_sel | input | SEL_W | Filter code; window is 2^(code+4) prescaled ticks |
| pd_irq_en | input | 1 | Enables the power-down interrupt |
| pd_stat_clr | input | 1 | Write-one-to-clear strobe for the status |
| pd_stat | output | 1 | Pollable power-down status |
| pd_irq | output | 1 | Power-down interrupt |

## Verification
The bench builds the block with PRESCALE set to 3. Because this is not a power of two, the prescaler wrap and the window length are checked at a value that a shift-based shortcut would miss. MIO_N and SEL_W keep their defaults. Random segments use filter codes 0 to 2, so windows of 48 to 192 cycles qualify many times between interruptions. One directed run uses code 7 (6144 cycles) to check the widest counter setting at its exact boundary.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

  // Qualification states
  typedef enum logic [1:0] {
    PDF_REST  = 2'd0,   // request absent
    PDF_COUNT = 2'd1,   // request present, window running
    PDF_HELD  = 2'd2    // window completed, waiting for request to drop
  } pdf_state_e;

  // Smallest exponent of the window length
  localparam int PDF_EXP_BASE = 4;

  // Width able to hold 2^(max code + base)
  function automatic int cnt_width(input int sel_w);
    return (1 << sel_w) + PDF_EXP_BASE;
  endfunction

endpackage

// File: rtl/pdf_sync.sv
module pdf_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] r_q;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r_q <= '0;
          else        r_q <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r_q <= '0;
          else        r_q <= g_stage[s-1].r_q;
        end
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r_q;

endmodule

// File: rtl/pdf_req.sv
module pdf_req #(
  parameter int MIO_N = 2
) (
  input  logic             uart_irq_pend,
  input  logic             uart_tx_idle,
  input  logic             uart_rx_idle,
  input  logic             uart_pd_en,
  input  logic [MIO_N-1:0] mio_lvl,
  input  logic [MIO_N-1:0] mio_irq_pol,
  input  logic [MIO_N-1:0] mio_pd_en,
  output logic             req
);

  logic             uart_quiet;
  logic [MIO_N-1:0] pin_quiet;

  // R1: serial channel quiet only if nothing pending and both directions idle
  assign uart_quiet = uart_pd_en & ~uart_irq_pend & uart_tx_idle & uart_rx_idle;

  // R2: a pin is quiet at the level opposite its interrupt level
  genvar i;
  generate
    for (i = 0; i < MIO_N; i++) begin : g_pin
      assign pin_quiet[i] = mio_pd_en[i] & (mio_lvl[i] ^ mio_irq_pol[i]);
    end
  endgenerate

  assign req = uart_quiet | (|pin_quiet);

endmodule

// File: rtl/pdf_timer.sv
module pdf_timer
  import pdf_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int SEL_W    = 3,
  parameter int CNT_W    = cnt_width(SEL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  output logic             stat,
  output logic [CNT_W-1:0] cnt
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  pdf_state_e       state_q, state_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stat_q, stat_d;
  logic             tick;
  logic [CNT_W-1:0] shamt;
  logic [CNT_W-1:0] limit;

  // Prescaler enable; runs only while a window is being timed
  assign tick  = (pre_q == PRE_LAST);
  assign shamt = CNT_W'(sel) + CNT_W'(PDF_EXP_BASE);
  assign limit = (CNT_W'(1) << shamt) - CNT_W'(1);

  always_comb begin
    state_d = state_q;
    pre_d   = pre_q;
    cnt_d   = cnt_q;
    stat_d  = stat_q;
    if (!req) begin
      // R4/R5: any gap restarts everything
      state_d = PDF_REST;
      pre_d   = '0;
      cnt_d   = '0;
      stat_d  = 1'b0;
    end else begin
      unique case (state_q)
        PDF_REST, PDF_COUNT: begin
          state_d = PDF_COUNT;
          pre_d   = tick ? '0 : pre_q + PRE_W'(1);
          if (tick) begin
            if (cnt_q >= limit) begin
              // R3/R9: window complete, set has priority over clear
              stat_d  = 1'b1;
              state_d = PDF_HELD;
              cnt_d   = '0;
              pre_d   = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        PDF_HELD: begin
          // R6: acknowledged event stays down until the request drops
          if (clr) stat_d = 1'b0;
        end
        default: begin
          state_d = PDF_REST;
          pre_d   = '0;
          cnt_d   = '0;
          stat_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PDF_REST;
      pre_q   <= '0;
      cnt_q   <= '0;
      stat_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
      stat_q  <= stat_d;
    end
  end

  assign stat = stat_q;
  assign cnt  = cnt_q;

endmodule

// File: rtl/pwr_idle_filter.sv
module pwr_idle_filter
  import pdf_pkg::*;
#(
  parameter int PRESCALE    = 4,
  parameter int SEL_W       = 3,
  parameter int MIO_N       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uart_irq_pend,
  input  logic             uart_tx_idle,
  input  logic             uart_rx_idle,
  input  logic             uart_pd_en,
  input  logic [MIO_N-1:0] mio_pin,
  input  logic [MIO_N-1:0] mio_irq_pol,
  input  logic [MIO_N-1:0] mio_pd_en,
  input  logic [SEL_W-1:0] filt_sel,
  input  logic             pd_irq_en,
  input  logic             pd_stat_clr,
  output logic             pd_stat,
  output logic             pd_irq
);

  localparam int CNT_W = cnt_width(SEL_W);

  logic [MIO_N-1:0] mio_sync;
  logic             req_any;
  logic [CNT_W-1:0] tmr_cnt;

  pdf_sync #(
    .W      (MIO_N),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mio_pin),
    .q     (mio_sync)
  );

  pdf_req #(
    .MIO_N (MIO_N)
  ) u_req (
    .uart_irq_pend (uart_irq_pend),
    .uart_tx_idle  (uart_tx_idle),
    .uart_rx_idle  (uart_rx_idle),
    .uart_pd_en    (uart_pd_en),
    .mio_lvl       (mio_sync),
    .mio_irq_pol   (mio_irq_pol),
    .mio_pd_en     (mio_pd_en),
    .req           (req_any)
  );

  pdf_timer #(
    .PRESCALE (PRESCALE),
    .SEL_W    (SEL_W),
    .CNT_W    (CNT_W)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_any),
    .sel   (filt_sel),
    .clr   (pd_stat_clr),
    .stat  (pd_stat),
    .cnt   (tmr_cnt)
  );

  // R7: interrupt is the gated status
  assign pd_irq = pd_stat & pd_irq_en;

endmodule

// File: rtl/pwr_idle_filter_chk.sv
module pwr_idle_filter_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_any,
  input logic             pd_stat_clr,
  input logic             pd_irq_en,
  input logic             pd_stat,
  input logic             pd_irq,
  input logic [CNT_W-1:0] tmr_cnt
);

  // R3: status only rises out of a cycle with the request present
  a_r3_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_stat) |-> $past(req_any));

  // R4: a gap in the request clears the timer
  a_r4_gap_resets_timer: assert property (@(posedge clk) disable iff (!rst_n)
    !req_any |=> (tmr_cnt == '0));

  // R5: status drops after the request goes away
  a_r5_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !req_any |=> !pd_stat);

  // R6: acknowledge clears a set status
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_stat && pd_stat_clr) |=> !pd_stat);

  // R6: without acknowledge and with request present the status holds
  a_r6_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_stat && req_any && !pd_stat_clr) |=> pd_stat);

  // R7: interrupt implies status, and is silent when disabled
  a_r7_irq_needs_stat: assert property (@(posedge clk) disable iff (!rst_n)
    pd_irq |-> pd_stat);
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_irq_en |-> !pd_irq);

endmodule

bind pwr_idle_filter pwr_idle_filter_chk #(
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_any     (req_any),
  .pd_stat_clr (pd_stat_clr),
  .pd_irq_en   (pd_irq_en),
  .pd_stat     (pd_stat),
  .pd_irq      (pd_irq),
  .tmr_cnt     (tmr_cnt)
);

// File: tb/pwr_idle_filter_tb.sv
`timescale 1ns/1ps
module pwr_idle_filter_tb;

  localparam int PRESCALE = 3;
  localparam int SEL_W    = 3;
  localparam int MIO_N    = 2;

  logic             clk;
  logic             rst_n;
  logic             uart_irq_pend;
  logic             uart_tx_idle;
  logic             uart_rx_idle;
  logic             uart_pd_en;
  logic [MIO_N-1:0] mio_pin;
  logic [MIO_N-1:0] mio_irq_pol;
  logic [MIO_N-1:0] mio_pd_en;
  logic [SEL_W-1:0] filt_sel;
  logic             pd_irq_en;
  logic             pd_stat_clr;
  logic             pd_stat;
  logic             pd_irq;

  int checks;
  int errors;
  bit done;

  pwr_idle_filter #(
    .PRESCALE (PRESCALE),
    .SEL_W    (SEL_W),
    .MIO_N    (MIO_N)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .uart_irq_pend (uart_irq_pend),
    .uart_tx_idle  (uart_tx_idle),
    .uart_rx_idle  (uart_rx_idle),
    .uart_pd_en    (uart_pd_en),
    .mio_pin       (mio_pin),
    .mio_irq_pol   (mio_irq_pol),
    .mio_pd_en     (mio_pd_en),
    .filt_sel      (filt_sel),
    .pd_irq_en     (pd_irq_en),
    .pd_stat_clr   (pd_stat_clr),
    .pd_stat       (pd_stat),
    .pd_irq        (pd_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model from the requirements ----------------
  function automatic int need_edges(input logic [SEL_W-1:0] code);
    return (1 << (int'(code) + 4)) * PRESCALE;
  endfunction

  function automatic bit req_of(input logic pend, input logic tx, input logic rx,
                                input logic uen, input logic [MIO_N-1:0] lvl,
                                input logic [MIO_N-1:0] pol, input logic [MIO_N-1:0] men);
    bit r;
    r = uen && !pend && tx && rx;
    for (int i = 0; i < MIO_N; i++) if (men[i] && (lvl[i] != pol[i])) r = 1'b1;
    return r;
  endfunction

  logic [MIO_N-1:0] m_s1, m_s2;
  int               m_run;
  bit               m_held;
  bit               m_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_run <= 0; m_held <= 1'b0; m_stat <= 1'b0;
    end else begin
      m_s1 <= mio_pin;
      m_s2 <= m_s1;
      if (!req_of(uart_irq_pend, uart_tx_idle, uart_rx_idle, uart_pd_en,
                  m_s2, mio_irq_pol, mio_pd_en)) begin
        m_run <= 0; m_held <= 1'b0; m_stat <= 1'b0;
      end else if (m_held) begin
        if (pd_stat_clr) m_stat <= 1'b0;
      end else if (m_run + 1 >= need_edges(filt_sel)) begin
        m_run <= 0; m_held <= 1'b1; m_stat <= 1'b1;
      end else begin
        m_run <= m_run + 1;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 R4 R5 R6 status vs model", pd_stat, m_stat);
      chk("R7 irq vs model", pd_irq, m_stat & pd_irq_en);
    end
  end

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // all sources off, pins at their interrupt level
  task automatic quiet_off();
    uart_pd_en    = 1'b0;
    mio_pd_en     = '0;
    uart_irq_pend = 1'b1;
    uart_tx_idle  = 1'b0;
    uart_rx_idle  = 1'b0;
    mio_pin       = mio_irq_pol;
    pd_stat_clr   = 1'b0;
    wait_edges(3);
  endtask

  task automatic uart_quiet_on();
    uart_pd_en    = 1'b1;
    uart_irq_pend = 1'b0;
    uart_tx_idle  = 1'b1;
    uart_rx_idle  = 1'b1;
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    void'($urandom(32'h1D1E_F00D));
    rst_n = 1'b0;
    uart_irq_pend = 1'b1; uart_tx_idle = 1'b0; uart_rx_idle = 1'b0; uart_pd_en = 1'b0;
    mio_pin = '0; mio_irq_pol = '0; mio_pd_en = '0; filt_sel = '0;
    pd_irq_en = 1'b1; pd_stat_clr = 1'b0;
    wait_edges(3);
    chk("R8 reset status", pd_stat, 1'b0);
    chk("R8 reset irq", pd_irq, 1'b0);
    rst_n = 1'b1;
    wait_edges(1);
    chk("R8 status after reset", pd_stat, 1'b0);

    // R3: exact window, code 0 -> 48 edges
    quiet_off();
    filt_sel = 3'd0;
    uart_quiet_on();
    wait_edges(need_edges(3'd0) - 1);
    chk("R3 one edge early", pd_stat, 1'b0);
    wait_edges(1);
    chk("R3 window reached", pd_stat, 1'b1);
    chk("R7 irq enabled", pd_irq, 1'b1);
    pd_irq_en = 1'b0;
    wait_edges(1);
    chk("R7 irq masked", pd_irq, 1'b0);
    chk("R7 status pollable", pd_stat, 1'b1);
    pd_irq_en = 1'b1;

    // R6: acknowledge, no re-raise while request stays
    pd_stat_clr = 1'b1;
    wait_edges(1);
    pd_stat_clr = 1'b0;
    chk("R6 acknowledge clears", pd_stat, 1'b0);
    wait_edges(200);
    chk("R6 no re-raise", pd_stat, 1'b0);

    // R5 and R1: requalify, then a pending interrupt ends it
    uart_tx_idle = 1'b0;
    wait_edges(1);
    uart_tx_idle = 1'b1;
    wait_edges(need_edges(3'd0));
    chk("R6 requalified after drop", pd_stat, 1'b1);
    uart_irq_pend = 1'b1;
    wait_edges(1);
    chk("R5 R1 pending interrupt drops status", pd_stat, 1'b0);

    // R4: one-cycle gap restarts the window
    quiet_off();
    uart_quiet_on();
    wait_edges(40);
    uart_rx_idle = 1'b0;
    wait_edges(1);
    uart_rx_idle = 1'b1;
    wait_edges(need_edges(3'd0) - 1);
    chk("R4 gap restarted window", pd_stat, 1'b0);
    wait_edges(1);
    chk("R4 full window after gap", pd_stat, 1'b1);

    // R1: transmitter busy alone blocks
    quiet_off();
    uart_quiet_on();
    uart_tx_idle = 1'b0;
    wait_edges(150);
    chk("R1 tx busy blocks", pd_stat, 1'b0);
    uart_quiet_on();
    uart_pd_en = 1'b0;
    wait_edges(150);
    chk("R1 source disabled", pd_stat, 1'b0);

    // R2: pin 0, high raises interrupt, low is quiet
    mio_irq_pol = 2'b01;
    quiet_off();
    mio_pd_en = 2'b01;
    mio_pin   = 2'b00;
    wait_edges(2 + need_edges(3'd0) - 1);
    chk("R2 pin sync plus window early", pd_stat, 1'b0);
    wait_edges(1);
    chk("R2 pin quiet qualifies", pd_stat, 1'b1);
    mio_pin = 2'b01;
    wait_edges(2);
    chk("R2 synchronizer delay", pd_stat, 1'b1);
    wait_edges(1);
    chk("R2 pin active drops", pd_stat, 1'b0);
    mio_pd_en = 2'b00;
    mio_pin   = 2'b00;
    wait_edges(150);
    chk("R2 pin disabled", pd_stat, 1'b0);

    // R2: pin 1 with low polarity, high is quiet
    mio_irq_pol = 2'b00;
    quiet_off();
    mio_pd_en = 2'b10;
    mio_pin   = 2'b10;
    wait_edges(2 + need_edges(3'd0));
    chk("R2 pin1 high quiet", pd_stat, 1'b1);

    // R9: clear held high across completion
    quiet_off();
    uart_quiet_on();
    pd_stat_clr = 1'b1;
    wait_edges(need_edges(3'd0));
    chk("R9 set wins over clear", pd_stat, 1'b1);
    wait_edges(1);
    chk("R9 clear next edge", pd_stat, 1'b0);
    pd_stat_clr = 1'b0;

    // R3: widest code
    quiet_off();
    filt_sel = 3'd7;
    uart_quiet_on();
    wait_edges(need_edges(3'd7) - 1);
    chk("R3 code 7 early", pd_stat, 1'b0);
    wait_edges(1);
    chk("R3 code 7 reached", pd_stat, 1'b1);

    // Random segments, compared cycle by cycle against the model
    for (int seg = 0; seg < 30; seg++) begin
      quiet_off();
      filt_sel    = SEL_W'($urandom % 3);
      mio_irq_pol = MIO_N'($urandom);
      for (int st = 0; st < 20; st++) begin
        int hold;
        uart_pd_en = ($urandom % 4) != 0;
        mio_pd_en  = MIO_N'($urandom);
        if (($urandom % 10) < 7) uart_quiet_on();
        else begin
          uart_irq_pend = $urandom % 2;
          uart_tx_idle  = $urandom % 2;
          uart_rx_idle  = $urandom % 2;
        end
        for (int i = 0; i < MIO_N; i++)
          mio_pin[i] = mio_irq_pol[i] ^ (($urandom % 4) != 0);
        pd_irq_en = ($urandom % 3) != 0;
        hold = 1 + int'($urandom % 160);
        for (int c = 0; c < hold; c++) begin
          pd_stat_clr = ($urandom % 24) == 0;
          wait_edges(1);
        end
        pd_stat_clr = 1'b0;
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_800_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule